// File: doc/BRIEF.md
# Quadruplet Strip Centroid Filter and Averager

This block takes the per-layer cluster results of one four-layer strip chamber quadruplet and reduces them to a single space point. Each layer presents five things: a hit-present bit, the centroid position, the cluster width in strips, the summed charge and a pileup flag. A layer is dropped when its cluster is one of the following:
- too narrow, which looks like noise;
- too wide, which looks like a delta ray or a neutron;
- carrying too much charge, which looks like a neutron;
- marked as pileup.

The positions of the surviving layers are summed. The sum is then divided by the number of layers kept. The divisor is one of a handful of small integers, so a short table of reciprocals and a single multiply replace a general divider.

The result comes from a short fixed-latency pipeline with these outputs:
- the averaged point;
- a mask of the layers that contributed;
- the number of layers kept;
- a valid strobe.

When every layer is rejected, no point is produced. A separate strobe reports the empty result instead.

The width window and the charge ceiling are inputs. They can change between events without a reset.

Top module: `scf_centroid_avg`

## Requirements
- R1: A layer whose cluster width is below `cfgMinWidth` is excluded. A width equal to `cfgMinWidth` is kept.
- R2: A layer whose cluster width is above `cfgMaxWidth` is excluded. A width equal to `cfgMaxWidth` is kept. A new `cfgMaxWidth` applies to the next event.
- R3: A layer whose total charge is above `cfgChargeMax` is excluded. A charge equal to `cfgChargeMax` is kept.
- R4: A layer with its pileup bit set is excluded.
- R5: A layer with its hit bit clear is excluded.
- R6: `outPoint` equals the sum of the kept positions divided by the kept count, rounded down, for a count of 1, 2, 3 or 4.
- R7: Bit i of `outMask` is 1 exactly when layer i was kept. Bit 0 is layer 0, whose fields sit in the lowest slice of each packed input. `outCount` equals the number of set mask bits.
- R8: When no layer is kept, `outValid` stays low, `outNone` pulses for one cycle, and `outMask`, `outCount` and `outPoint` read zero.
- R9: An event sampled with `inValid` high at a rising edge produces its `outValid` or `outNone` pulse right after the third rising edge, counting the sampling edge as the first. Nothing is flagged before that.
- R10: After reset, `outValid`, `outNone`, `outMask`, `outCount` and `outPoint` are all zero.
- R11: Events presented on consecutive cycles produce results on consecutive cycles, in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Layer results of one event are present this cycle |
| inHit | input | NLAYER | Per-layer hit-present bit |
| inPileup | input | NLAYER | Per-layer pileup flag (a strip was active before the trigger) |
| inPos | input | NLAYER*POS_W | Per-layer centroid position, layer 0 in the low slice |
| inWidth | input | NLAYER*WID_W | Per-layer cluster width in strips |
| inCharge | input | NLAYER*CHG_W | Per-layer summed cluster charge |
| cfgMinWidth | input | WID_W | Smallest accepted cluster width |
| cfgMaxWidth | input | WID_W | Largest accepted cluster width |
| cfgChargeMax | input | CHG_W | Largest accepted cluster charge |
| outValid | output | 1 | Averaged point is present |
| outNone | output | 1 | Event had no usable layer |
| outPoint | output | POS_W | Averaged position |
| outMask | output | NLAYER | Layers used in the average |
| outCount | output | CNT_W | Number of layers used |

## Verification
The result of every event is due right after the third rising edge, counting the edge that samples it as the first. It is registered once each in the classify, sum and scale stages.

The bench drives inputs on falling edges and reads the outputs on the third falling edge after the drive. On the falling edge before that, it confirms that neither strobe has risen early. The back-to-back case reads two results on two consecutive falling edges.

// File: rtl/scf_pkg.sv
package scf_pkg;

  // Strobes from the control pipeline into the datapath stages.
  typedef struct packed {
    logic capture;     // classify stage loads the incoming layers
    logic accumulate;  // sum stage loads the kept positions
    logic publish;     // scale stage drives the outputs
  } scfStrobe_t;

endpackage

// File: rtl/scf_ctrl.sv
module scf_ctrl
  import scf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output scfStrobe_t strobe
);

  logic stage1Valid;
  logic stage2Valid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      stage2Valid <= stage1Valid;
    end
  end

  assign strobe.capture    = inValid;
  assign strobe.accumulate = stage1Valid;
  assign strobe.publish    = stage2Valid;

endmodule

// File: rtl/scf_datapath.sv
module scf_datapath
  import scf_pkg::*;
#(
  parameter int NLAYER = 4,
  parameter int POS_W  = 12,
  parameter int WID_W  = 4,
  parameter int CHG_W  = 10,
  localparam int CNT_W = $clog2(NLAYER + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  scfStrobe_t              strobe,
  input  logic [NLAYER-1:0]       inHit,
  input  logic [NLAYER-1:0]       inPileup,
  input  logic [NLAYER*POS_W-1:0] inPos,
  input  logic [NLAYER*WID_W-1:0] inWidth,
  input  logic [NLAYER*CHG_W-1:0] inCharge,
  input  logic [WID_W-1:0]        cfgMinWidth,
  input  logic [WID_W-1:0]        cfgMaxWidth,
  input  logic [CHG_W-1:0]        cfgChargeMax,
  output logic                    outValid,
  output logic                    outNone,
  output logic [POS_W-1:0]        outPoint,
  output logic [NLAYER-1:0]       outMask,
  output logic [CNT_W-1:0]        outCount
);

  // The sum grows by log2(layers). The reciprocal keeps enough extra
  // fraction bits that a rounded-up reciprocal still floors exactly.
  localparam int SUM_W    = POS_W + $clog2(NLAYER);
  localparam int FRAC_K   = SUM_W + $clog2(NLAYER);
  localparam int RECIP_W  = FRAC_K + 1;
  localparam int PROD_W   = SUM_W + RECIP_W;
  localparam int TAB_SIZE = 2 ** CNT_W;

  // ---------------- stage 1: per-layer classification ----------------
  logic [NLAYER-1:0]            keepNext;
  logic [NLAYER-1:0][POS_W-1:0] posNext;

  for (genvar g = 0; g < NLAYER; g++) begin : g_layer
    logic [WID_W-1:0] layerWidth;
    logic [CHG_W-1:0] layerCharge;
    logic             widthOk;
    logic             chargeOk;

    assign layerWidth  = inWidth[g*WID_W +: WID_W];
    assign layerCharge = inCharge[g*CHG_W +: CHG_W];
    assign widthOk     = (layerWidth >= cfgMinWidth) && (layerWidth <= cfgMaxWidth);
    assign chargeOk    = (layerCharge <= cfgChargeMax);
    assign keepNext[g] = inHit[g] && !inPileup[g] && widthOk && chargeOk;
    assign posNext[g]  = keepNext[g] ? inPos[g*POS_W +: POS_W] : '0;
  end

  logic [NLAYER-1:0]            keepR;
  logic [NLAYER-1:0][POS_W-1:0] posR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keepR <= '0;
      posR  <= '0;
    end else if (strobe.capture) begin
      keepR <= keepNext;
      posR  <= posNext;
    end
  end

  // ---------------- stage 2: sum and count ----------------
  logic [SUM_W-1:0]  sumNext;
  logic [CNT_W-1:0]  cntNext;
  logic [SUM_W-1:0]  sumR;
  logic [CNT_W-1:0]  cntR;
  logic [NLAYER-1:0] maskR;

  always_comb begin
    sumNext = '0;
    cntNext = '0;
    for (int i = 0; i < NLAYER; i++) begin
      sumNext = sumNext + SUM_W'(posR[i]);
      cntNext = cntNext + CNT_W'(keepR[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumR  <= '0;
      cntR  <= '0;
      maskR <= '0;
    end else if (strobe.accumulate) begin
      sumR  <= sumNext;
      cntR  <= cntNext;
      maskR <= keepR;
    end
  end

  // ---------------- stage 3: reciprocal multiply ----------------
  logic [RECIP_W-1:0] recipTab [TAB_SIZE];

  for (genvar n = 0; n < TAB_SIZE; n++) begin : g_recip
    if (n == 0 || n > NLAYER) begin : g_zero
      assign recipTab[n] = '0;
    end else begin : g_val
      assign recipTab[n] = RECIP_W'(((64'd1 << FRAC_K) + 64'(n) - 64'd1) / 64'(n));
    end
  end

  logic [PROD_W-1:0] product;
  logic [POS_W-1:0]  quotient;

  assign product  = PROD_W'(sumR) * PROD_W'(recipTab[cntR]);
  assign quotient = POS_W'(product >> FRAC_K);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outNone  <= 1'b0;
      outPoint <= '0;
      outMask  <= '0;
      outCount <= '0;
    end else begin
      outValid <= strobe.publish && (cntR != '0);
      outNone  <= strobe.publish && (cntR == '0);
      if (strobe.publish) begin
        outPoint <= (cntR != '0) ? quotient : '0;
        outMask  <= maskR;
        outCount <= cntR;
      end
    end
  end

endmodule

// File: rtl/scf_centroid_avg.sv
module scf_centroid_avg
  import scf_pkg::*;
#(
  parameter int NLAYER = 4,
  parameter int POS_W  = 12,
  parameter int WID_W  = 4,
  parameter int CHG_W  = 10,
  localparam int CNT_W = $clog2(NLAYER + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [NLAYER-1:0]       inHit,
  input  logic [NLAYER-1:0]       inPileup,
  input  logic [NLAYER*POS_W-1:0] inPos,
  input  logic [NLAYER*WID_W-1:0] inWidth,
  input  logic [NLAYER*CHG_W-1:0] inCharge,
  input  logic [WID_W-1:0]        cfgMinWidth,
  input  logic [WID_W-1:0]        cfgMaxWidth,
  input  logic [CHG_W-1:0]        cfgChargeMax,
  output logic                    outValid,
  output logic                    outNone,
  output logic [POS_W-1:0]        outPoint,
  output logic [NLAYER-1:0]       outMask,
  output logic [CNT_W-1:0]        outCount
);

  scfStrobe_t strobe;

  scf_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe)
  );

  scf_datapath #(
    .NLAYER (NLAYER),
    .POS_W  (POS_W),
    .WID_W  (WID_W),
    .CHG_W  (CHG_W)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .inHit        (inHit),
    .inPileup     (inPileup),
    .inPos        (inPos),
    .inWidth      (inWidth),
    .inCharge     (inCharge),
    .cfgMinWidth  (cfgMinWidth),
    .cfgMaxWidth  (cfgMaxWidth),
    .cfgChargeMax (cfgChargeMax),
    .outValid     (outValid),
    .outNone      (outNone),
    .outPoint     (outPoint),
    .outMask      (outMask),
    .outCount     (outCount)
  );

endmodule

// File: rtl/scf_checker.sv
module scf_checker #(
  parameter int NLAYER = 4,
  localparam int CNT_W = $clog2(NLAYER + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [NLAYER-1:0] inHit,
  input logic [NLAYER-1:0] inPileup,
  input logic              outValid,
  input logic              outNone,
  input logic [NLAYER-1:0] outMask,
  input logic [CNT_W-1:0]  outCount
);

  // R9: every sampled event yields a strobe three edges later
  a_r9_result_due: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##3 (outValid || outNone));

  // R9: no strobe without an event three edges earlier
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (outValid || outNone) |-> $past(inValid, 3));

  // R8: the two strobes never coincide
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && outNone));

  // R8: an empty result carries no mask and no count
  a_r8_empty_fields: assert property (@(posedge clk) disable iff (!rstN)
    outNone |-> (outMask == '0 && outCount == '0));

  // R7: the count matches the mask, and a valid point has a layer
  a_r7_mask_count: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outMask != '0 && 32'(outCount) == $countones(outMask)));

  // R4: a layer flagged as pileup never reaches the mask
  a_r4_pileup_dropped: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##3 ((outMask & $past(inPileup, 3)) == '0));

  // R5: a layer without a hit never reaches the mask
  a_r5_nohit_dropped: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##3 ((outMask & ~$past(inHit, 3)) == '0));

endmodule

bind scf_centroid_avg scf_checker #(.NLAYER(NLAYER)) i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inHit    (inHit),
  .inPileup (inPileup),
  .outValid (outValid),
  .outNone  (outNone),
  .outMask  (outMask),
  .outCount (outCount)
);

// File: tb/test_scf_centroid_avg.sv
module test_scf_centroid_avg;

  localparam int NL    = 4;
  localparam int PW    = 12;
  localparam int WW    = 4;
  localparam int CW    = 10;
  localparam int CNTW  = 3;
  localparam time TCLK = 20ns;

  logic             clk = 1'b0;
  logic             rstN;
  logic             inValid;
  logic [NL-1:0]    inHit;
  logic [NL-1:0]    inPileup;
  logic [NL*PW-1:0] inPos;
  logic [NL*WW-1:0] inWidth;
  logic [NL*CW-1:0] inCharge;
  logic [WW-1:0]    cfgMinWidth;
  logic [WW-1:0]    cfgMaxWidth;
  logic [CW-1:0]    cfgChargeMax;
  logic             outValid;
  logic             outNone;
  logic [PW-1:0]    outPoint;
  logic [NL-1:0]    outMask;
  logic [CNTW-1:0]  outCount;

  int testsRun = 0;
  int testsFailed = 0;

  int bPos [NL];
  int bWid [NL];
  int bChg [NL];
  bit bPu  [NL];
  bit bHit [NL];

  always #(TCLK / 2) clk = ~clk;

  scf_centroid_avg i_scf_centroid_avg (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .inHit        (inHit),
    .inPileup     (inPileup),
    .inPos        (inPos),
    .inWidth      (inWidth),
    .inCharge     (inCharge),
    .cfgMinWidth  (cfgMinWidth),
    .cfgMaxWidth  (cfgMaxWidth),
    .cfgChargeMax (cfgChargeMax),
    .outValid     (outValid),
    .outNone      (outNone),
    .outPoint     (outPoint),
    .outMask      (outMask),
    .outCount     (outCount)
  );

  task automatic checkEq(input string tag, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic setLayer(input int i, input int pos, input int wid, input int chg,
                          input bit pu, input bit hit);
    bPos[i] = pos;
    bWid[i] = wid;
    bChg[i] = chg;
    bPu[i]  = pu;
    bHit[i] = hit;
  endtask

  task automatic setGood(input int p0, input int p1, input int p2, input int p3);
    setLayer(0, p0, 3, 200, 1'b0, 1'b1);
    setLayer(1, p1, 4, 250, 1'b0, 1'b1);
    setLayer(2, p2, 3, 180, 1'b0, 1'b1);
    setLayer(3, p3, 5, 300, 1'b0, 1'b1);
  endtask

  // Expected result taken from the requirements alone.
  task automatic calcExp(output int mask, output int cnt, output int avg);
    int sum = 0;
    mask = 0;
    cnt  = 0;
    for (int i = 0; i < NL; i++) begin
      if (bHit[i] && !bPu[i] && bWid[i] >= int'(cfgMinWidth) &&
          bWid[i] <= int'(cfgMaxWidth) && bChg[i] <= int'(cfgChargeMax)) begin
        mask |= (1 << i);
        cnt++;
        sum += bPos[i];
      end
    end
    avg = (cnt == 0) ? 0 : sum / cnt;
  endtask

  task automatic drive();
    for (int i = 0; i < NL; i++) begin
      inPos[i*PW +: PW]    = PW'(bPos[i]);
      inWidth[i*WW +: WW]  = WW'(bWid[i]);
      inCharge[i*CW +: CW] = CW'(bChg[i]);
      inPileup[i]          = bPu[i];
      inHit[i]             = bHit[i];
    end
    inValid = 1'b1;
  endtask

  task automatic checkResult(input string tag, input int mask, input int cnt, input int avg);
    checkEq(tag, "outValid", int'(outValid), int'(cnt != 0));
    checkEq(tag, "outNone", int'(outNone), int'(cnt == 0));
    checkEq(tag, "outMask", int'(outMask), mask);
    checkEq(tag, "outCount", int'(outCount), cnt);
    checkEq(tag, "outPoint", int'(outPoint), avg);
  endtask

  // Drive at a falling edge; result is read three falling edges later.
  task automatic runCase(input string tag);
    int mask, cnt, avg;
    calcExp(mask, cnt, avg);
    drive();
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    checkEq({tag, " R9"}, "early strobe", int'(outValid || outNone), 0);
    @(negedge clk);
    checkResult(tag, mask, cnt, avg);
  endtask

  task automatic testReset();
    checkEq("R10", "outValid", int'(outValid), 0);
    checkEq("R10", "outNone", int'(outNone), 0);
    checkEq("R10", "outMask", int'(outMask), 0);
    checkEq("R10", "outCount", int'(outCount), 0);
    checkEq("R10", "outPoint", int'(outPoint), 0);
  endtask

  task automatic testAllKept();
    setGood(100, 104, 98, 102);
    runCase("R6 four kept R7");
  endtask

  task automatic testNoise();
    setGood(500, 510, 520, 530);
    setLayer(2, 900, 1, 150, 1'b0, 1'b1);  // single strip: dropped
    setLayer(1, 512, 2, 150, 1'b0, 1'b1);  // width at minimum: kept
    runCase("R1 noise");
  endtask

  task automatic testDelta();
    setGood(1000, 1004, 1010, 1002);
    setLayer(0, 2000, 6, 300, 1'b0, 1'b1); // too wide: dropped
    setLayer(3, 1006, 5, 300, 1'b0, 1'b1); // width at maximum: kept
    runCase("R2 delta");
  endtask

  task automatic testCharge();
    setGood(300, 301, 302, 303);
    setLayer(1, 3000, 4, 601, 1'b0, 1'b1); // charge above ceiling
    setLayer(2, 305, 4, 600, 1'b0, 1'b1);  // charge at ceiling: kept
    runCase("R3 neutron");
  endtask

  task automatic testPileup();
    setGood(40, 44, 48, 52);
    setLayer(3, 4000, 3, 200, 1'b1, 1'b1);
    runCase("R4 pileup");
  endtask

  task automatic testNoHit();
    setGood(700, 710, 720, 730);
    setLayer(0, 3333, 3, 200, 1'b0, 1'b0);
    runCase("R5 nohit");
  endtask

  task automatic testSingle();
    setGood(11, 22, 33, 44);
    setLayer(0, 11, 1, 200, 1'b0, 1'b1);
    setLayer(1, 22, 3, 200, 1'b1, 1'b1);
    setLayer(3, 44, 3, 200, 1'b0, 1'b0);
    runCase("R6 one kept");
  endtask

  task automatic testThreeFloor();
    setGood(10, 10, 11, 0);
    setLayer(3, 999, 9, 200, 1'b0, 1'b1);
    runCase("R6 three floor");
  endtask

  task automatic testMaxPos();
    setGood(4095, 4095, 4095, 4095);
    runCase("R6 full scale");
    setGood(4095, 4094, 4094, 0);
    setLayer(3, 0, 3, 200, 1'b0, 1'b0);
    runCase("R6 three near full scale");
  endtask

  task automatic testAllRejected();
    setLayer(0, 10, 1, 100, 1'b0, 1'b1);
    setLayer(1, 20, 7, 100, 1'b0, 1'b1);
    setLayer(2, 30, 3, 900, 1'b0, 1'b1);
    setLayer(3, 40, 3, 100, 1'b1, 1'b1);
    runCase("R8 none");
    @(negedge clk);
    checkEq("R8 pulse", "outNone second cycle", int'(outNone), 0);
  endtask

  task automatic testConfigChange();
    cfgMaxWidth = 4'd7;
    setGood(200, 204, 208, 212);
    setLayer(2, 208, 6, 200, 1'b0, 1'b1); // now within the window
    runCase("R2 config");
    cfgMaxWidth = 4'd5;
  endtask

  task automatic testBackToBack();
    int mA, cA, aA, mB, cB, aB;
    setGood(60, 62, 64, 66);
    calcExp(mA, cA, aA);
    drive();
    @(negedge clk);
    setGood(80, 90, 0, 0);
    setLayer(2, 0, 3, 200, 1'b0, 1'b0);
    setLayer(3, 0, 3, 200, 1'b0, 1'b0);
    calcExp(mB, cB, aB);
    drive();
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    checkResult("R11 first", mA, cA, aA);
    @(negedge clk);
    checkResult("R11 second", mB, cB, aB);
  endtask

  initial begin
    #(TCLK * 200000);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    rstN         = 1'b0;
    inValid      = 1'b0;
    inHit        = '0;
    inPileup     = '0;
    inPos        = '0;
    inWidth      = '0;
    inCharge     = '0;
    cfgMinWidth  = 4'd2;
    cfgMaxWidth  = 4'd5;
    cfgChargeMax = 10'd600;
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAllKept();
    testNoise();
    testDelta();
    testCharge();
    testPileup();
    testNoHit();
    testSingle();
    testThreeFloor();
    testMaxPos();
    testAllRejected();
    testConfigChange();
    testBackToBack();
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule